// File: doc/BRIEF.md
# Integer Execution Unit with Packed Condition Flags

This block is the arithmetic stage of a small register-based processor core. Each cycle with `in_valid` high, it takes an operation code, a destination operand, a source operand and the current contents of the implicit accumulator pair. The accumulator pair is two 32-bit registers, a high word and a low word, that form one 64-bit value. The block returns its results one clock later, marked by `out_valid`, together with separate write enables for the destination register and for the accumulator pair.

The supported operations are addition (with a register source or a sign-extended byte immediate), subtraction, compare, signed multiply and signed divide. The block owns the 32-bit status word. Four condition bits sit at fixed positions in that word, and they are updated according to per-operation rules.

Signed divide is combinational. It works on magnitudes and truncates toward zero. A zero divisor, or a quotient that does not fit in a signed 32-bit value, raises `div_error` and blocks every register write. Instruction decode, the register file, memory and the program counter are handled elsewhere.

Top module: `alu_flags_unit`

## Requirements
- R1: The status word `flags` holds carry at bit 0, zero at bit 6, sign at bit 7 and overflow at bit 11. Every other bit always reads 0.
- R2: Opcode 0 (add) writes dst+src to `dst_result` with `dst_we`=1. It sets carry from the carry out of bit 31, zero on a zero result, sign from bit 31 of the result, and overflow on signed overflow.
- R3: Opcode 1 (add immediate) sign-extends `src_val[7:0]` to 32 bits, then behaves as opcode 0. Bits 31:8 of `src_val` have no effect.
- R4: Opcode 2 (subtract) writes dst-src. Carry is set when a borrow occurs (dst < src as unsigned values). Overflow is set on signed overflow. Zero and sign follow the result.
- R5: Opcode 3 (compare) updates the four flags exactly as opcode 2 would, and asserts neither write enable.
- R6: Opcode 4 (signed multiply) writes the 64-bit signed product of `acc_lo` and `src_val` to `pair_hi`:`pair_lo`, with `pair_we`=1.
- R7: For opcode 4, carry and overflow are both set when the high word of the product is not the sign extension of the low word. Zero and sign reflect the full 64-bit product.
- R8: Opcode 5 (signed divide) divides `acc_hi`:`acc_lo` by `src_val`. The quotient, truncated toward zero, goes to `pair_lo`; the remainder, which carries the dividend's sign, goes to `pair_hi`.
- R9: For opcode 5, a zero divisor or a quotient outside the signed 32-bit range asserts `div_error` and clears both write enables.
- R10: Opcode 5 and the unused opcodes 6 and 7 leave `flags` unchanged. Opcodes 6 and 7 write nothing.
- R11: Synchronous reset clears `flags`, `out_valid`, all write enables and `div_error`.
- R12: Results appear exactly one clock after the `in_valid` cycle. In a cycle without `in_valid`, `out_valid` falls, no write enable or `div_error` is asserted on the following cycle, and `flags` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 add, 1 add imm, 2 sub, 3 cmp, 4 mul, 5 div) |
| dst_val | input | 32 | Destination operand |
| src_val | input | 32 | Source operand, or immediate in bits 7:0 |
| acc_hi | input | 32 | High word of the accumulator pair |
| acc_lo | input | 32 | Low word of the accumulator pair |
| out_valid | output | 1 | Results valid |
| dst_result | output | 32 | Destination result |
| dst_we | output | 1 | Destination write enable |
| pair_hi | output | 32 | High word of pair result (product high / remainder) |
| pair_lo | output | 32 | Low word of pair result (product low / quotient) |
| pair_we | output | 1 | Accumulator pair write enable |
| div_error | output | 1 | Divide by zero or quotient overflow |
| flags | output | 32 | Status word with packed condition bits |

## Verification
The embedded assertions check several properties on every cycle:
- reserved status bits stay at zero;
- compare never writes a register;
- a divide error never comes with a write;
- divide and the unused opcodes leave the status word as it was;
- idle cycles produce no writes.

The arithmetic values themselves can only be shown by the bench's scenarios. These cover carry and borrow out of bit 31, signed overflow at the positive and negative limits, immediate sign extension with junk in the upper source bits, product spill into the high word, truncation toward zero for negative dividends, and the quotient-range limit on both sides of its edge.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STATUS_W = 32;

    localparam int unsigned CARRY_POS = 0;
    localparam int unsigned ZERO_POS  = 6;
    localparam int unsigned SIGN_POS  = 7;
    localparam int unsigned OVF_POS   = 11;

    localparam logic [STATUS_W-1:0] FLAG_MASK =
        (STATUS_W'(1) << CARRY_POS) | (STATUS_W'(1) << ZERO_POS) |
        (STATUS_W'(1) << SIGN_POS)  | (STATUS_W'(1) << OVF_POS);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDI = 3'd1,
        OP_SUB  = 3'd2,
        OP_CMP  = 3'd3,
        OP_IMUL = 3'd4,
        OP_IDIV = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zero;
        logic carry;
    } cond_t;

    function automatic logic [STATUS_W-1:0] pack_flags(cond_t c);
        logic [STATUS_W-1:0] w;
        w            = '0;
        w[CARRY_POS] = c.carry;
        w[ZERO_POS]  = c.zero;
        w[SIGN_POS]  = c.sgn;
        w[OVF_POS]   = c.ovf;
        return w;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] res,
    output cond_t        cond
);
    logic [W:0] wide;

    always_comb begin
        if (do_sub) wide = {1'b0, a} - {1'b0, b};
        else        wide = {1'b0, a} + {1'b0, b};
        res        = wide[W-1:0];
        cond.carry = wide[W];
        cond.zero  = (wide[W-1:0] == '0);
        cond.sgn   = wide[W-1];
        if (do_sub) cond.ovf = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
        else        cond.ovf = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
    import alu_flags_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output cond_t          cond
);
    logic signed [2*W-1:0] sa, sb;

    always_comb begin
        sa         = $signed({{W{a[W-1]}}, a});
        sb         = $signed({{W{b[W-1]}}, b});
        prod       = sa * sb;
        cond.carry = (prod[2*W-1:W] != {W{prod[W-1]}});
        cond.ovf   = cond.carry;
        cond.zero  = (prod == '0);
        cond.sgn   = prod[2*W-1];
    end
endmodule

// File: rtl/alu_div.sv
module alu_div
    import alu_flags_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         err
);
    localparam logic [2*W-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [2*W-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] dvd, mag_n, den, q_mag, r_mag;
    logic [W-1:0]   mag_d;
    logic           neg_n, neg_d, neg_q, zero_d, q_big;

    always_comb begin
        dvd    = {num_hi, num_lo};
        neg_n  = num_hi[W-1];
        neg_d  = divisor[W-1];
        neg_q  = neg_n ^ neg_d;
        zero_d = (divisor == '0);
        mag_n  = neg_n ? (~dvd + 1'b1) : dvd;
        mag_d  = neg_d ? (~divisor + 1'b1) : divisor;
        den    = {{W{1'b0}}, zero_d ? W'(1) : mag_d};
        q_mag  = mag_n / den;
        r_mag  = mag_n % den;
        q_big  = neg_q ? (q_mag > NEG_LIM) : (q_mag > POS_LIM);
        err    = zero_d || q_big;
        quot   = neg_q ? (~q_mag[W-1:0] + 1'b1) : q_mag[W-1:0];
        rem    = neg_n ? (~r_mag[W-1:0] + 1'b1) : r_mag[W-1:0];
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  op,
    input  logic [31:0] dst_val,
    input  logic [31:0] src_val,
    input  logic [31:0] acc_hi,
    input  logic [31:0] acc_lo,
    output logic        out_valid,
    output logic [31:0] dst_result,
    output logic        dst_we,
    output logic [31:0] pair_hi,
    output logic [31:0] pair_lo,
    output logic        pair_we,
    output logic        div_error,
    output logic [31:0] flags
);
    localparam int unsigned W     = WORD_W;
    localparam int unsigned IMM_W = 8;

    alu_op_e        op_e, op_q;
    logic [W-1:0]   as_b, as_res, dv_q, dv_r;
    logic [2*W-1:0] mul_p;
    cond_t          as_c, mul_c;
    logic           as_sub, dv_err;

    assign op_e   = alu_op_e'(op);
    assign as_sub = (op_e == OP_SUB) || (op_e == OP_CMP);
    assign as_b   = (op_e == OP_ADDI) ?
                    {{(W-IMM_W){src_val[IMM_W-1]}}, src_val[IMM_W-1:0]} : src_val;

    alu_addsub #(.W(W)) u_addsub (
        .a(dst_val), .b(as_b), .do_sub(as_sub), .res(as_res), .cond(as_c)
    );

    alu_mul #(.W(W)) u_mul (
        .a(acc_lo), .b(src_val), .prod(mul_p), .cond(mul_c)
    );

    alu_div #(.W(W)) u_div (
        .num_hi(acc_hi), .num_lo(acc_lo), .divisor(src_val),
        .quot(dv_q), .rem(dv_r), .err(dv_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            dst_result <= '0;
            dst_we     <= 1'b0;
            pair_hi    <= '0;
            pair_lo    <= '0;
            pair_we    <= 1'b0;
            div_error  <= 1'b0;
            flags      <= '0;
            op_q       <= OP_NOP7;
        end else begin
            out_valid <= in_valid;
            dst_we    <= 1'b0;
            pair_we   <= 1'b0;
            div_error <= 1'b0;
            if (in_valid) begin
                op_q <= op_e;
                unique case (op_e)
                    OP_ADD, OP_ADDI, OP_SUB: begin
                        dst_result <= as_res;
                        dst_we     <= 1'b1;
                        flags      <= pack_flags(as_c);
                    end
                    OP_CMP: flags <= pack_flags(as_c);
                    OP_IMUL: begin
                        pair_hi <= mul_p[2*W-1:W];
                        pair_lo <= mul_p[W-1:0];
                        pair_we <= 1'b1;
                        flags   <= pack_flags(mul_c);
                    end
                    OP_IDIV: begin
                        div_error <= dv_err;
                        if (!dv_err) begin
                            pair_hi <= dv_r;
                            pair_lo <= dv_q;
                            pair_we <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: reserved status bits never set
    a_r1_flag_mask: assert property (@(posedge clk) disable iff (rst)
        (flags & ~FLAG_MASK) == '0);

    // R5: compare writes no register
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_q == OP_CMP) |-> (!dst_we && !pair_we));

    // R6: multiply always writes the pair
    a_r6_mul_pair_we: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_q == OP_IMUL) |-> (pair_we && !dst_we));

    // R9: a divide error blocks all writes
    a_r9_err_no_write: assert property (@(posedge clk) disable iff (rst)
        div_error |-> (!dst_we && !pair_we && op_q == OP_IDIV));

    // R10: divide and unused opcodes hold the status word
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (op_q == OP_IDIV || op_q == OP_NOP6 || op_q == OP_NOP7))
        |-> (flags == $past(flags)));

    // R12: no write without a result
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!dst_we && !pair_we && !div_error));

    // R12: result follows an accepted operation by one cycle
    a_r12_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [31:0] dst_val, src_val, acc_hi, acc_lo;
    logic        out_valid, dst_we, pair_we, div_error;
    logic [31:0] dst_result, pair_hi, pair_lo, flags;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [31:0] dst;
        logic        dwe;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        pwe;
        logic        err;
        logic [31:0] flg;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model_flags;
    int          popped = 0;
    int          pushed = 0;

    always #5 clk = ~clk;

    alu_flags_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .dst_val(dst_val), .src_val(src_val), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .out_valid(out_valid), .dst_result(dst_result), .dst_we(dst_we),
        .pair_hi(pair_hi), .pair_lo(pair_lo), .pair_we(pair_we),
        .div_error(div_error), .flags(flags)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkflags(logic c, logic z, logic s, logic o);
        logic [31:0] f = '0;
        f[0] = c; f[6] = z; f[7] = s; f[11] = o;
        return f;
    endfunction

    task automatic issue(string tag, int code, logic [31:0] d, logic [31:0] s,
                         logic [31:0] hi, logic [31:0] lo);
        exp_t        e;
        longint      sd, ss, r, dv, dr, q, rm;
        logic [32:0] w;
        e.tag = tag; e.dst = '0; e.dwe = 0; e.hi = '0; e.lo = '0;
        e.pwe = 0; e.err = 0;
        sd = longint'($signed(d));
        ss = (code == 1) ? longint'($signed(s[7:0])) : longint'($signed(s));
        case (code)
            0, 1: begin
                w = {1'b0, d} + {1'b0, 32'(ss)};
                r = sd + ss;
                model_flags = mkflags(w[32], w[31:0] == 0, w[31],
                                      r > 64'sd2147483647 || r < -64'sd2147483648);
                e.dst = w[31:0]; e.dwe = (code <= 1);
            end
            2, 3: begin
                r = sd - ss;
                model_flags = mkflags(d < s, d == s, r[31],
                                      r > 64'sd2147483647 || r < -64'sd2147483648);
                e.dst = 32'(r); e.dwe = (code == 2);
            end
            4: begin
                r = longint'($signed(lo)) * ss;
                model_flags = mkflags(r > 64'sd2147483647 || r < -64'sd2147483648,
                                      r == 0, r < 0,
                                      r > 64'sd2147483647 || r < -64'sd2147483648);
                e.hi = r[63:32]; e.lo = r[31:0]; e.pwe = 1;
            end
            5: begin
                dv = longint'({hi, lo});
                if (ss == 0 || (dv == 64'sh8000000000000000 && ss == -1)) begin
                    e.err = 1;
                end else begin
                    q  = dv / ss;
                    rm = dv % ss;
                    if (q > 64'sd2147483647 || q < -64'sd2147483648) e.err = 1;
                    else begin
                        e.hi = rm[31:0]; e.lo = q[31:0]; e.pwe = 1;
                    end
                end
            end
            default: ;
        endcase
        e.flg = model_flags;
        @(negedge clk);
        in_valid = 1; op = 3'(code);
        dst_val = d; src_val = s; acc_hi = hi; acc_lo = lo;
        sb_q.push_back(e);
        pushed++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; op = 3'd4; src_val = 32'hFFFF_FFFF; acc_lo = 32'h7;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    chk("R12 unexpected out_valid", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    popped++;
                    chk({e.tag, " dst_we"}, dst_we, e.dwe);
                    chk({e.tag, " pair_we"}, pair_we, e.pwe);
                    chk({e.tag, " div_error"}, div_error, e.err);
                    chk({e.tag, " flags"}, flags, e.flg);
                    if (e.dwe) chk({e.tag, " dst_result"}, dst_result, e.dst);
                    if (e.pwe) chk({e.tag, " pair"}, {pair_hi, pair_lo}, {e.hi, e.lo});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        rst = 1; in_valid = 0; op = 0;
        dst_val = 0; src_val = 0; acc_hi = 0; acc_lo = 0;
        model_flags = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 flags", flags, 0);
        chk("R11 out_valid", out_valid, 0);
        chk("R11 enables", {dst_we, pair_we, div_error}, 0);
        @(negedge clk); rst = 0;

        issue("R2 add small",     0, 32'd4,        32'd1,        0, 0);
        issue("R2 add carry",     0, 32'hFFFFFFFF, 32'd1,        0, 0);
        issue("R2 add ovf",       0, 32'h7FFFFFFF, 32'd1,        0, 0);
        issue("R3 addi neg",      1, 32'd4,        32'h123456F8, 0, 0);
        issue("R3 addi pos",      1, 32'h10,       32'hABCDEF7F, 0, 0);
        issue("R4 sub borrow",    2, 32'd4,        32'd6,        0, 0);
        issue("R4 sub ovf",       2, 32'h80000000, 32'd1,        0, 0);
        issue("R5 cmp equal",     3, 32'd5,        32'd5,        0, 0);
        issue("R5 cmp less",      3, 32'd4,        32'd6,        0, 0);
        idle();
        // R12: idle cycle raises nothing, flags held
        @(posedge clk); #1;
        chk("R12 idle out_valid", out_valid, 0);
        chk("R12 idle enables", {dst_we, pair_we, div_error}, 0);
        chk("R12 idle flags", flags, model_flags);
        issue("R6 R7 mul neg",    4, 0, 32'd6,       0, 32'hFFFFFFFF);
        issue("R7 mul spill",     4, 0, 32'h10000,   0, 32'h10000);
        issue("R7 mul zero",      4, 0, 32'd5,       0, 32'd0);
        issue("R7 mul min",       4, 0, 32'hFFFFFFFF, 0, 32'h80000000);
        issue("R8 div pos",       5, 0, 32'd3,       0, 32'd7);
        issue("R8 div neg",       5, 0, 32'd3,       32'hFFFFFFFF, 32'hFFFFFFF9);
        issue("R8 div negdiv",    5, 0, 32'hFFFFFFFD, 0, 32'd7);
        issue("R9 div zero",      5, 0, 32'd0,       0, 32'd7);
        issue("R9 div big",       5, 0, 32'd1,       32'd1, 32'd0);
        issue("R9 div min neg1",  5, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000);
        issue("R8 div min by1",   5, 0, 32'd1,       32'hFFFFFFFF, 32'h80000000);
        issue("R10 nop6",         6, 32'd1, 32'd2,   32'd3, 32'd4);
        issue("R10 nop7",         7, 32'd1, 32'd2,   32'd3, 32'd4);
        idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R12 all results seen", popped, pushed);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule